// File: doc/BRIEF.md
# Sliding-Window Decoder Recursion Sequencer

This block sequences one window of a sliding-window log-domain trellis decoder. The datapath is a shared bank of eight add-compare-select units, and this block does not include it. A single start pulse runs one window of 128 bit indices through three phases. The forward recursion comes first, at 7 cycles per index in ascending order, and writes one alpha set per index. The pre-backward recursion follows, at 7 cycles per index over the first 24 indices of the following window, in descending order. The backward recursion comes last, at 24 cycles per index in descending order. It reads back one alpha set per index and produces one extrinsic LLR per index. A full window takes 4136 cycles.

Each backward index is split into three sub-phases. Beta metrics take 7 cycles, delta metrics take 4 cycles and the LLR reduction takes 13 cycles. The block also tells the datapath where each recursion takes its starting metrics from. The forward pass uses fixed metrics only for window zero and otherwise carries over alpha from the previous window. The backward pass uses fixed metrics only for the last window and otherwise uses the betas left by the pre-backward run. The last window has no following window, so it skips the pre-backward pass. When it finishes, a one-cycle done pulse is raised.

Top module: `win_sched_ctrl`

## Requirements
- R1: After a synchronous reset, phase is idle (code 0), bit index and step are 0, and done, llr_valid, both alpha strobes and both init flags are low.
- R2: A start seen while the phase is idle begins a window: on the next cycle phase is forward (code 1), index 0, step 0. A start seen while a window is running has no effect.
- R3: The forward phase runs steps 0 to 6 on each index and takes indices 0 up to 127.
- R4: alpha_we is high exactly on step 6 of every forward index, with bit_idx giving the alpha address.
- R5: For a window whose last-window flag is low, the pre-backward phase (code 2) follows the forward phase and runs steps 0 to 6 on indices 23 down to 0. A last window never enters it.
- R6: The backward phase (code 3) runs steps 0 to 23 on indices 127 down to 0. alpha_re is high exactly on step 0 of each backward index, with bit_idx giving the address.
- R7: In the backward phase, sub_phase is 0 (beta) on steps 0–6, 1 (delta) on steps 7–10 and 2 (LLR) on steps 11–23. llr_valid is high only on step 23. Outside the backward phase, sub_phase is 0 and llr_valid is low.
- R8: fwd_init_fixed is high throughout a window started with win_idx equal to 0. bwd_init_fixed is high throughout a window started with last_win high. Both values are captured at start and are low while idle.
- R9: A window lasts 4136 non-idle cycles, or 3968 for a last window, and then returns to idle.
- R10: done is high for exactly one cycle, the cycle right after the final LLR step of a last window, and is never high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a window (accepted only when idle) |
| win_idx | input | 8 | Position of this window in the block; 0 marks the first |
| last_win | input | 1 | This window is the final one |
| phase | output | 2 | 0 idle, 1 forward, 2 pre-backward, 3 backward |
| sub_phase | output | 2 | Backward sub-phase: 0 beta, 1 delta, 2 LLR |
| bit_idx | output | 7 | Current bit index within the window |
| step | output | 5 | Cycle number within the current index |
| alpha_we | output | 1 | Write strobe for one alpha set at bit_idx |
| alpha_re | output | 1 | Read strobe for one alpha set at bit_idx |
| llr_valid | output | 1 | Extrinsic LLR for bit_idx completes this cycle |
| fwd_init_fixed | output | 1 | Forward recursion starts from fixed metrics |
| bwd_init_fixed | output | 1 | Backward recursion starts from fixed metrics |
| done | output | 1 | One-cycle pulse after the last window's final LLR |

## Verification
Nearly all state of this block is visible cycle by cycle on the phase, bit_idx and step outputs. The bench compares all of them on every cycle against a schedule it builds itself, so a wrong step limit, an index counting the wrong way or a phase change one cycle off shows up within a single index, which is at most 24 cycles. A wrongly captured flag shows up as a wrong init output on the first cycle of the window. A pre-backward pass that is wrongly entered or wrongly skipped shows up as a wrong phase code at the end of the forward pass. A misplaced done pulse shows up in one of the two idle cycles checked after each window.

// File: rtl/win_sched_pkg.sv
package win_sched_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_FWD  = 2'd1,
    PH_PRE  = 2'd2,
    PH_BWD  = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    SUB_BETA  = 2'd0,
    SUB_DELTA = 2'd1,
    SUB_LLR   = 2'd2
  } sub_e;
endpackage

// File: rtl/wsc_step_cnt.sv
module wsc_step_cnt #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] lim_m1,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  assign wrap = en && (cnt == lim_m1);

  always_ff @(posedge clk) begin
    if (rst || clr || wrap) cnt <= '0;
    else if (en)            cnt <= cnt + 1'b1;
  end

  a_r3_step_bounded: assert property (@(posedge clk) disable iff (rst)
    en |-> cnt <= lim_m1);
endmodule

// File: rtl/wsc_idx_cnt.sv
module wsc_idx_cnt #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         adv,
  input  logic         up,
  output logic [W-1:0] idx
);
  always_ff @(posedge clk) begin
    if (rst)       idx <= '0;
    else if (load) idx <= load_val;
    else if (adv)  idx <= up ? idx + 1'b1 : idx - 1'b1;
  end
endmodule

// File: rtl/wsc_sub_decode.sv
module wsc_sub_decode
  import win_sched_pkg::*;
#(
  parameter int W         = 5,
  parameter int BETA_CYC  = 7,
  parameter int DELTA_CYC = 4,
  parameter int LLR_CYC   = 13
) (
  input  logic         in_bwd,
  input  logic [W-1:0] step,
  output logic [1:0]   sub,
  output logic         llr_last
);
  localparam int DELTA_END = BETA_CYC + DELTA_CYC;
  localparam int LAST_STEP = DELTA_END + LLR_CYC - 1;

  always_comb begin
    sub      = SUB_BETA;
    llr_last = 1'b0;
    if (in_bwd) begin
      if (int'(step) >= DELTA_END)     sub = SUB_LLR;
      else if (int'(step) >= BETA_CYC) sub = SUB_DELTA;
      llr_last = (int'(step) == LAST_STEP);
    end
  end
endmodule

// File: rtl/win_sched_ctrl.sv
module win_sched_ctrl
  import win_sched_pkg::*;
#(
  parameter int WIN_LEN   = 128,
  parameter int PRE_LEN   = 24,
  parameter int FWD_CYC   = 7,
  parameter int PRE_CYC   = 7,
  parameter int BETA_CYC  = 7,
  parameter int DELTA_CYC = 4,
  parameter int LLR_CYC   = 13,
  parameter int WCNT_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WCNT_W-1:0] win_idx,
  input  logic              last_win,
  output logic [1:0]        phase,
  output logic [1:0]        sub_phase,
  output logic [$clog2(WIN_LEN)-1:0] bit_idx,
  output logic [$clog2(BETA_CYC+DELTA_CYC+LLR_CYC+1)-1:0] step,
  output logic              alpha_we,
  output logic              alpha_re,
  output logic              llr_valid,
  output logic              fwd_init_fixed,
  output logic              bwd_init_fixed,
  output logic              done
);
  localparam int BWD_CYC = BETA_CYC + DELTA_CYC + LLR_CYC;
  localparam int IDX_W   = $clog2(WIN_LEN);
  localparam int STEP_W  = $clog2(BWD_CYC + 1);

  phase_e             ph_q, ph_d;
  logic               start_acc, busy, step_wrap, idx_term, seg_end;
  logic [STEP_W-1:0]  lim_m1;
  logic [IDX_W-1:0]   load_val;
  logic               ff_q, bf_q, done_q;

  assign busy      = (ph_q != PH_IDLE);
  assign start_acc = start && !busy;

  always_comb begin
    unique case (ph_q)
      PH_FWD:  lim_m1 = STEP_W'(FWD_CYC - 1);
      PH_PRE:  lim_m1 = STEP_W'(PRE_CYC - 1);
      PH_BWD:  lim_m1 = STEP_W'(BWD_CYC - 1);
      default: lim_m1 = '0;
    endcase
  end

  wsc_step_cnt #(.W(STEP_W)) u_step (
    .clk(clk), .rst(rst), .clr(start_acc), .en(busy),
    .lim_m1(lim_m1), .cnt(step), .wrap(step_wrap)
  );

  assign idx_term = (ph_q == PH_FWD) ? (bit_idx == IDX_W'(WIN_LEN - 1))
                                     : (bit_idx == '0);
  assign seg_end  = busy && step_wrap && idx_term;

  always_comb begin
    ph_d = ph_q;
    if (start_acc) ph_d = PH_FWD;
    else if (seg_end) begin
      unique case (ph_q)
        PH_FWD:  ph_d = bf_q ? PH_BWD : PH_PRE;
        PH_PRE:  ph_d = PH_BWD;
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (ph_d)
      PH_PRE:  load_val = IDX_W'(PRE_LEN - 1);
      PH_BWD:  load_val = IDX_W'(WIN_LEN - 1);
      default: load_val = '0;
    endcase
  end

  wsc_idx_cnt #(.W(IDX_W)) u_idx (
    .clk(clk), .rst(rst), .load(start_acc || seg_end), .load_val(load_val),
    .adv(step_wrap && !idx_term), .up(ph_q == PH_FWD), .idx(bit_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_IDLE;
      ff_q   <= 1'b0;
      bf_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      done_q <= seg_end && (ph_q == PH_BWD) && bf_q;
      if (start_acc) begin
        ff_q <= (win_idx == '0);
        bf_q <= last_win;
      end else if (seg_end && ph_q == PH_BWD) begin
        ff_q <= 1'b0;
        bf_q <= 1'b0;
      end
    end
  end

  wsc_sub_decode #(
    .W(STEP_W), .BETA_CYC(BETA_CYC), .DELTA_CYC(DELTA_CYC), .LLR_CYC(LLR_CYC)
  ) u_sub (
    .in_bwd(ph_q == PH_BWD), .step(step), .sub(sub_phase), .llr_last(llr_valid)
  );

  assign phase          = ph_q;
  assign alpha_we       = (ph_q == PH_FWD) && (step == STEP_W'(FWD_CYC - 1));
  assign alpha_re       = (ph_q == PH_BWD) && (step == '0);
  assign fwd_init_fixed = ff_q;
  assign bwd_init_fixed = bf_q;
  assign done           = done_q;

  a_r2_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && start && ph_q != PH_BWD) |=> ph_q != PH_IDLE && $stable(bf_q));
  a_r3_fwd_ascending: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_FWD && step_wrap && !idx_term) |=> bit_idx == IDX_W'($past(bit_idx) + 1'b1));
  a_r5_no_pre_on_last: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_PRE) |-> !bf_q);
  a_r7_llr_in_llr_sub: assert property (@(posedge clk) disable iff (rst)
    llr_valid |-> (ph_q == PH_BWD) && (sub_phase == SUB_LLR));
  a_r10_done_after_last_bwd: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(ph_q) == PH_BWD && $past(bf_q) && ph_q == PH_IDLE);
endmodule

// File: tb/sim_win_sched_ctrl.sv
module sim_win_sched_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [7:0] win_idx = '0;
  logic last_win = 1'b0;
  logic [1:0] phase, sub_phase;
  logic [6:0] bit_idx;
  logic [4:0] step;
  logic alpha_we, alpha_re, llr_valid, fwd_init_fixed, bwd_init_fixed, done;

  int checks = 0;
  int fails  = 0;

  typedef struct packed {
    logic [1:0] ph;
    logic [6:0] idx;
    logic [4:0] st;
    logic [1:0] sub;
    logic we, re, lv, ff, bf, dn;
  } exp_t;

  exp_t q[$];
  exp_t e;

  always #4 clk = ~clk;

  win_sched_ctrl u0 (
    .clk(clk), .rst(rst), .start(start), .win_idx(win_idx), .last_win(last_win),
    .phase(phase), .sub_phase(sub_phase), .bit_idx(bit_idx), .step(step),
    .alpha_we(alpha_we), .alpha_re(alpha_re), .llr_valid(llr_valid),
    .fwd_init_fixed(fwd_init_fixed), .bwd_init_fixed(bwd_init_fixed), .done(done)
  );

  task automatic chk(input string tag, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (time %0t)", tag, act, exp_v, $time);
    end
  endtask

  // Scoreboard monitor: one expected item per cycle, compared mid-cycle
  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      e = q.pop_front();
      chk("R2/R5/R9 phase", phase, e.ph);
      chk("R3/R5/R6 bit_idx", bit_idx, e.idx);
      chk("R3/R6 step", step, e.st);
      chk("R7 sub_phase", sub_phase, e.sub);
      chk("R4 alpha_we", alpha_we, e.we);
      chk("R6 alpha_re", alpha_re, e.re);
      chk("R7 llr_valid", llr_valid, e.lv);
      chk("R8 fwd_init_fixed", fwd_init_fixed, e.ff);
      chk("R8 bwd_init_fixed", bwd_init_fixed, e.bf);
      chk("R10 done", done, e.dn);
    end
  end

  function automatic exp_t mk(int ph, int idx, int st, int sub,
                              bit we, bit re, bit lv, bit ff, bit bf, bit dn);
    exp_t x;
    x.ph = 2'(ph); x.idx = 7'(idx); x.st = 5'(st); x.sub = 2'(sub);
    x.we = we; x.re = re; x.lv = lv; x.ff = ff; x.bf = bf; x.dn = dn;
    return x;
  endfunction

  // Driver: start one window, push its full expected schedule
  task automatic run_window(input int wi, input bit last, input bit intrude);
    bit ff;
    ff = (wi == 0);
    @(negedge clk);
    win_idx = 8'(wi); last_win = last; start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    win_idx = 8'hAA; last_win = ~last;
    for (int i = 0; i < 128; i++)                       // R3, R4
      for (int s = 0; s < 7; s++)
        q.push_back(mk(1, i, s, 0, s == 6, 1'b0, 1'b0, ff, last, 1'b0));
    if (!last)                                          // R5
      for (int i = 23; i >= 0; i--)
        for (int s = 0; s < 7; s++)
          q.push_back(mk(2, i, s, 0, 1'b0, 1'b0, 1'b0, ff, last, 1'b0));
    for (int i = 127; i >= 0; i--)                      // R6, R7
      for (int s = 0; s < 24; s++)
        q.push_back(mk(3, i, s, (s < 7) ? 0 : (s < 11) ? 1 : 2,
                       1'b0, s == 0, s == 23, ff, last, 1'b0));
    q.push_back(mk(0, 0, 0, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, last)); // R9, R10
    q.push_back(mk(0, 0, 0, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0)); // R10 single pulse
    if (intrude) begin                                  // R2: start while busy
      repeat (300) @(negedge clk);
      win_idx = 8'd0; last_win = ~last; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (1500) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (q.size() == 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 phase", phase, 0);
    chk("R1 bit_idx", bit_idx, 0);
    chk("R1 step", step, 0);
    chk("R1 done", done, 0);
    chk("R1 strobes", {alpha_we, alpha_re, llr_valid}, 0);
    chk("R1 init flags", {fwd_init_fixed, bwd_init_fixed}, 0);
    run_window(0, 1'b0, 1'b0);   // first window
    run_window(1, 1'b0, 1'b1);   // middle window with ignored starts
    run_window(2, 1'b1, 1'b0);   // last window, no pre-backward
    run_window(0, 1'b1, 1'b1);   // single-window block
    repeat (3) @(negedge clk);
    chk("R9 stays idle", phase, 0);
    chk("R10 no stray done", done, 0);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule